// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

A port of general-purpose pins behind a small memory-mapped register bus. Software drives each pin by writing an output value and a drive-enable bit, and samples the pin level through a read-only register fed by a two-flop synchroniser. Every writable register can be reached at three addresses: a plain overwrite, an OR-in alias and a bit-clear alias. Software can therefore change any single bit without a read-modify-write sequence.

Each pin also watches its own synchronised level for an interrupt event. Two configuration bits choose between edge and level sensitivity and between the rising/high and falling/low sense. A per-pin routing bit decides whether an event is latched into the sticky status register. A separate per-pin enable then gates the latched status onto one shared interrupt line for the whole port. Software clears a latched event by writing ones to the status clear alias. A level-sensitive source whose pin is still active latches again on the very next cycle.

Top module: `gpio_irq_port`

## Requirements
- R1: After a synchronous reset, every register reads zero, `pin_out` and `pin_oe` are zero and `irq` is low.
- R2: For the writable registers, offset +0x0 of a register replaces its value, +0x4 ORs the write data into it, +0x8 clears the bits that are one in the write data, and +0xC has no effect. Register bases: drive enable 0xB00, output value 0x700, interrupt enable 0x1100, route 0x1000, polarity 0x1300, level select 0x1200, status 0x1400. A port index adds 0x10 per port.
- R3: `pin_out` always equals the output value register and `pin_oe` always equals the drive-enable register (1 = pin driven).
- R4: The input register at 0x900 returns `pin_in` delayed by two clock edges of synchronisation, whatever the drive enable. Writes to it have no effect.
- R5: With p the polarity bit and l the level-select bit of a pin, {p,l} = 00 detects a falling edge, 01 a low level, 10 a rising edge and 11 a high level, all on the synchronised input.
- R6: A pin whose route bit is 0 never sets its status bit through detection.
- R7: Writing ones to the status clear alias (0x1408) clears those status bits. A routed pin in level mode that is still at its active level sets its bit again on the next edge.
- R8: `irq` is a registered output: after each clock edge it is high exactly when status AND interrupt enable was nonzero before that edge.
- R9: When a status write (any alias) and a detected event hit the same bit at the same edge, the event wins and the bit is set.
- R10: Read data appears on `bus_rdata` after the edge that samples `bus_rd` and holds until the next read. A set or clear alias reads the underlying register, while offset +0xC and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output value per pin |
| pin_oe | output | 32 | Drive enable per pin |
| irq | output | 1 | Combined port interrupt |

## Verification
The hardest state to reach from the ports is a clear write to status landing at the same edge as a fresh detection on that bit. Edge events last one cycle, and the pin input reaches the detector three edges late. The stimulus avoids hunting for that cycle by using a high-level source that stays active. Every cycle then carries an event, so a clear alias write, and then an overwrite of status, both land on a live event by construction. The behavioural model in the bench checks status, `irq` and read data on every clock through that collision.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Alias decoded from the low address nibble
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_NONE  = 2'd3
  } alias_op_e;

  // Register selector; the first six index the configuration array
  typedef enum logic [3:0] {
    SEL_DOUT  = 4'd0,
    SEL_OE    = 4'd1,
    SEL_ROUTE = 4'd2,
    SEL_EN    = 4'd3,
    SEL_LEV   = 4'd4,
    SEL_POL   = 4'd5,
    SEL_STAT  = 4'd6,
    SEL_DIN   = 4'd7,
    SEL_NONE  = 4'd8
  } reg_sel_e;

  localparam int CFG_REGS = 6;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] lev,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] route,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= smp;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      logic hit;
      always_comb begin
        case ({pol[i], lev[i]})
          2'b00:   hit = ~smp[i] &  prev_q[i];
          2'b01:   hit = ~smp[i];
          2'b10:   hit =  smp[i] & ~prev_q[i];
          default: hit =  smp[i];
        endcase
      end
      assign evt[i] = route[i] & hit;
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS    = 32,
  parameter int AW       = 16,
  parameter int PORT_IDX = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  input  logic             bus_wr,
  input  logic             bus_rd,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam int            STRIDE = 16 * PORT_IDX;
  localparam logic [AW-1:0] A_DOUT  = AW'(32'h0700 + STRIDE);
  localparam logic [AW-1:0] A_DIN   = AW'(32'h0900 + STRIDE);
  localparam logic [AW-1:0] A_OE    = AW'(32'h0B00 + STRIDE);
  localparam logic [AW-1:0] A_ROUTE = AW'(32'h1000 + STRIDE);
  localparam logic [AW-1:0] A_EN    = AW'(32'h1100 + STRIDE);
  localparam logic [AW-1:0] A_LEV   = AW'(32'h1200 + STRIDE);
  localparam logic [AW-1:0] A_POL   = AW'(32'h1300 + STRIDE);
  localparam logic [AW-1:0] A_STAT  = AW'(32'h1400 + STRIDE);

  reg_sel_e         sel;
  alias_op_e        op;
  logic [AW-1:0]    page;
  logic [NPINS-1:0] cfg_q [CFG_REGS];
  logic [NPINS-1:0] status_q, status_d;
  logic [NPINS-1:0] din_s, evt;
  logic             irq_q;
  logic [NPINS-1:0] rdata_q;

  function automatic logic [NPINS-1:0] apply_op(alias_op_e o, logic [NPINS-1:0] cur,
                                                logic [NPINS-1:0] wd);
    case (o)
      OP_WRITE: return wd;
      OP_SET:   return cur | wd;
      OP_CLR:   return cur & ~wd;
      default:  return cur;
    endcase
  endfunction

  // Address decode
  assign page = {bus_addr[AW-1:4], 4'h0};

  always_comb begin
    case (page)
      A_DOUT:  sel = SEL_DOUT;
      A_DIN:   sel = SEL_DIN;
      A_OE:    sel = SEL_OE;
      A_ROUTE: sel = SEL_ROUTE;
      A_EN:    sel = SEL_EN;
      A_LEV:   sel = SEL_LEV;
      A_POL:   sel = SEL_POL;
      A_STAT:  sel = SEL_STAT;
      default: sel = SEL_NONE;
    endcase
    case (bus_addr[3:0])
      4'h0:    op = OP_WRITE;
      4'h4:    op = OP_SET;
      4'h8:    op = OP_CLR;
      default: op = OP_NONE;
    endcase
  end

  gpio_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (din_s)
  );

  gpio_irq_detect #(.W(NPINS)) u_detect (
    .clk   (clk),
    .rst   (rst),
    .smp   (din_s),
    .lev   (cfg_q[SEL_LEV]),
    .pol   (cfg_q[SEL_POL]),
    .route (cfg_q[SEL_ROUTE]),
    .evt   (evt)
  );

  // Configuration registers
  generate
    for (genvar k = 0; k < CFG_REGS; k++) begin : g_cfg
      always_ff @(posedge clk) begin
        if (rst)
          cfg_q[k] <= '0;
        else if (bus_wr && (sel == reg_sel_e'(k)))
          cfg_q[k] <= apply_op(op, cfg_q[k], bus_wdata);
      end
    end
  endgenerate

  // Status latch: detected events override software writes
  always_comb begin
    status_d = status_q;
    if (bus_wr && sel == SEL_STAT)
      status_d = apply_op(op, status_q, bus_wdata);
    status_d = status_d | evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= |(status_q & cfg_q[SEL_EN]);
    end
  end

  // Read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      if (op == OP_NONE)
        rdata_q <= '0;
      else begin
        case (sel)
          SEL_DOUT, SEL_OE, SEL_ROUTE, SEL_EN, SEL_LEV, SEL_POL:
                   rdata_q <= cfg_q[sel[2:0]];
          SEL_STAT: rdata_q <= status_q;
          SEL_DIN:  rdata_q <= din_s;
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = cfg_q[SEL_DOUT];
  assign pin_oe    = cfg_q[SEL_OE];
  assign irq       = irq_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NPINS    = 32,
  parameter int AW       = 16,
  parameter int PORT_IDX = 0
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    bus_addr,
  input logic [NPINS-1:0] bus_wdata,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [NPINS-1:0] bus_rdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq,
  input logic [NPINS-1:0] status_q,
  input logic [NPINS-1:0] en_q,
  input logic [NPINS-1:0] route_q,
  input logic [NPINS-1:0] evt
);
  localparam logic [AW-1:0] A_STAT_CLR = AW'(32'h1408 + 16 * PORT_IDX);

  // R1: outputs leave reset at zero
  p_reset_out_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pin_out == '0 && pin_oe == '0 && !irq));

  // R3: outputs only move when the bus writes
  p_out_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_wr) |-> ($stable(pin_out) && $stable(pin_oe)));

  // R6: unrouted pins gain no status from detection
  p_route_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_wr) |-> ((status_q & ~$past(status_q) & ~$past(route_q)) == '0));

  // R7: clear alias removes bits that had no concurrent event
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && bus_addr == A_STAT_CLR) |->
      ((status_q & $past(bus_wdata) & ~$past(evt)) == '0));

  // R8: interrupt follows gated status one edge later
  p_irq_track_r8: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(status_q & en_q)));

  // R9: every detected event lands in status
  p_evt_wins_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(evt) & ~status_q) == '0);

  // R10: read data holds without a read strobe
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(
  .NPINS(NPINS), .AW(AW), .PORT_IDX(PORT_IDX)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .status_q  (status_q),
  .en_q      (cfg_q[3]),
  .route_q   (cfg_q[2]),
  .evt       (evt)
);

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;
  localparam logic [15:0] A_DOUT  = 16'h0700;
  localparam logic [15:0] A_DIN   = 16'h0900;
  localparam logic [15:0] A_OE    = 16'h0B00;
  localparam logic [15:0] A_ROUTE = 16'h1000;
  localparam logic [15:0] A_EN    = 16'h1100;
  localparam logic [15:0] A_LEV   = 16'h1200;
  localparam logic [15:0] A_POL   = 16'h1300;
  localparam logic [15:0] A_STAT  = 16'h1400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  gpio_irq_port u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // Behavioural reference: registers kept in an associative map by base address
  logic [31:0] m_reg [logic [15:0]];
  logic [31:0] m_s1, m_s2, m_prev, m_rdata;
  logic        m_irq;

  task automatic model_reset();
    m_reg[A_DOUT] = 0; m_reg[A_OE] = 0; m_reg[A_ROUTE] = 0; m_reg[A_EN] = 0;
    m_reg[A_LEV] = 0; m_reg[A_POL] = 0; m_reg[A_STAT] = 0;
    m_s1 = 0; m_s2 = 0; m_prev = 0; m_rdata = 0; m_irq = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (rst) model_reset();
    else begin
      logic [31:0] ev;
      logic [15:0] base;
      logic [3:0]  off;
      bit          is_rw;
      ev = 0;
      for (int i = 0; i < 32; i++) begin
        bit p, l, cur, old;
        p = m_reg[A_POL][i]; l = m_reg[A_LEV][i]; cur = m_s2[i]; old = m_prev[i];
        if (m_reg[A_ROUTE][i]) begin
          if (l) ev[i] = p ? cur : !cur;
          else   ev[i] = p ? (cur && !old) : (!cur && old);
        end
      end
      base = {bus_addr[15:4], 4'h0};
      off  = bus_addr[3:0];
      is_rw = (base == A_DOUT || base == A_OE || base == A_ROUTE || base == A_EN ||
               base == A_LEV || base == A_POL || base == A_STAT);
      if (bus_rd) begin
        if (off != 0 && off != 4 && off != 8) m_rdata = 0;
        else if (base == A_DIN) m_rdata = m_s2;
        else if (is_rw) m_rdata = m_reg[base];
        else m_rdata = 0;
      end
      m_irq = |(m_reg[A_STAT] & m_reg[A_EN]);
      if (bus_wr && is_rw) begin
        if (off == 0) m_reg[base] = bus_wdata;
        else if (off == 4) m_reg[base] = m_reg[base] | bus_wdata;
        else if (off == 8) m_reg[base] = m_reg[base] & ~bus_wdata;
      end
      m_reg[A_STAT] = m_reg[A_STAT] | ev;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every falling edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 pin_out", pin_out, m_reg[A_DOUT]);
      chk("R3 pin_oe", pin_oe, m_reg[A_OE]);
      chk("R8 irq", {31'd0, irq}, {31'd0, m_irq});
      chk("R10 rdata", bus_rdata, m_rdata);
    end
  end

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, logic [31:0] exp, string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(5);
    rst = 1'b0;
    // R1: reset state
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rd(A_STAT, 0, "R1 status");
    rd(A_POL, 0, "R1 polarity");

    // R2: alias writes on the output value register
    wr(A_DOUT, 32'hF0F0_0000);
    wr(A_DOUT + 4, 32'h0000_000F);
    wr(A_DOUT + 8, 32'hF000_0000);
    rd(A_DOUT, 32'h00F0_000F, "R2 dout aliases");
    rd(A_DOUT + 4, 32'h00F0_000F, "R10 set alias reads base");
    wr(A_DOUT + 12, 32'hFFFF_FFFF);
    rd(A_DOUT, 32'h00F0_000F, "R2 offset C ignored");
    rd(A_DOUT + 12, 0, "R10 offset C reads zero");
    rd(16'h0200, 0, "R10 unmapped reads zero");

    // R3: drive enable on the port
    wr(A_OE + 4, 32'h0000_00FF);
    chk("R3 oe set", pin_oe, 32'h0000_00FF);
    chk("R3 out value", pin_out, 32'h00F0_000F);

    // R4: synchronised input, write ignored
    pin_in = 32'hA5A5_1234;
    idle(3);
    rd(A_DIN, 32'hA5A5_1234, "R4 input read");
    wr(A_DIN, 32'h0);
    rd(A_DIN + 8, 32'hA5A5_1234, "R4 input write ignored");

    // R5: four trigger modes on pins 0..3
    pin_in = 32'h0000_0001;
    idle(4);
    wr(A_POL, 32'h0000_000C);
    wr(A_LEV, 32'h0000_000A);
    wr(A_ROUTE, 32'h0000_000F);
    idle(4);
    // R7 / R9: low-level pin 1 survives a clear-all write
    wr(A_STAT + 8, 32'hFFFF_FFFF);
    rd(A_STAT, 32'h0000_0002, "R7 level re-sets after clear");
    pin_in = 32'h0000_000E;
    idle(5);
    rd(A_STAT, 32'h0000_000F, "R5 fall/low/rise/high captured");
    wr(A_STAT + 8, 32'h0000_000F);
    idle(2);
    rd(A_STAT, 32'h0000_0008, "R7 edges cleared, high level stays");

    // R8: interrupt gating
    chk("R8 irq masked", {31'd0, irq}, 0);
    wr(A_EN + 4, 32'h0000_0008);
    idle(2);
    chk("R8 irq enabled", {31'd0, irq}, 1);
    wr(A_EN + 8, 32'h0000_0008);
    idle(2);
    chk("R8 irq disabled", {31'd0, irq}, 0);

    // R9: overwrite of status collides with live high-level event
    wr(A_STAT, 32'h0000_0010);
    rd(A_STAT, 32'h0000_0018, "R9 event wins over overwrite");
    wr(A_EN, 32'h0000_0010);
    idle(2);
    chk("R8 software-set status raises irq", {31'd0, irq}, 1);

    // R6: unrouted pins stay quiet
    wr(A_ROUTE + 8, 32'h0000_000F);
    wr(A_STAT + 8, 32'hFFFF_FFFF);
    pin_in = 32'h0000_0000;
    idle(4);
    pin_in = 32'h0000_000F;
    idle(5);
    rd(A_STAT, 0, "R6 unrouted no capture");
    idle(2);
    chk("R8 irq after clear", {31'd0, irq}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule